// File: doc/BRIEF.md
# USB Host Channel Transfer Tracker

This block keeps the running state of one host channel while a USB transfer is in progress. Software programs four values before the transfer starts: the data PID for the first transaction, the number of packets it expects, the transfer byte size, and the start address of the memory buffer. From then on the block updates these values itself. Each successful packet lowers the packet count by one, moves the data PID to the value the next packet needs, and subtracts the packet's bytes from the remaining size. Each 32-bit bus beat moves the buffer address forward.

The transfer ends when the packet count reaches zero, or earlier when an IN packet arrives short. The block then drops its active flag and raises a completion flag. That flag stays set until software clears it with a write-one-to-clear. The packet scheduler, the serial engine and the bus master are outside the block. They report to it through single-cycle strobes: a packet-done strobe with a success flag and byte count, and a beat strobe.

Top module: `xfer_trk`

## Requirements
- R1: After reset the PID is 00, the packet count, the size and the address are zero, and both the active flag and the completion flag are low.
- R2: A write to selector 0 while idle does two things in the next cycle. It loads the PID from bits 1:0, the packet count from bits 11:2 and the size from bits 30:12. If bit 31 is set and the count is nonzero, it also raises the active flag. If bit 31 is set and the count is zero, it raises the completion flag and the channel stays idle. A write to selector 1 while idle loads the 32-bit address.
- R3: A successful packet while active lowers the packet count by one in the next cycle. Packet strobes while idle change nothing.
- R4: When a successful packet takes the count from 1 to 0, the next cycle shows the active flag low and the completion flag high.
- R5: A packet strobe with the success flag low leaves the PID, count, size and address unchanged.
- R6: PID codes are 00 DATA0, 10 DATA1, 01 DATA2, and 11 SETUP on a control channel or MDATA otherwise. After a successful packet, DATA0 and DATA1 swap, SETUP on a control channel becomes DATA1, and DATA2 and MDATA hold.
- R7: A beat strobe while active adds 4 to the address in the next cycle. A beat strobe while idle is ignored.
- R8: A successful packet subtracts its byte count from the size. The size saturates at zero.
- R9: On an IN channel, a successful packet of fewer than 64 bytes ends the transfer: the active flag goes low and the completion flag goes high, even if packets remain in the count.
- R10: The completion flag stays high until a write to selector 2 with bit 0 set. If that write falls in the same cycle as a completion, the flag is still set.
- R11: Writes to selectors 0 and 1 while the channel is active are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| wrEn | input | 1 | Register write strobe |
| wrSel | input | 2 | Write target: 0 transfer word, 1 address, 2 status clear |
| wrData | input | 32 | Write data |
| chanIsCtrl | input | 1 | Channel is a control channel |
| chanIsIn | input | 1 | Channel direction is IN |
| pktDone | input | 1 | A packet transaction finished this cycle |
| pktOk | input | 1 | The finished packet succeeded |
| pktBytes | input | 11 | Bytes carried by the finished packet |
| beat | input | 1 | One 32-bit bus data beat completed |
| pid | output | 2 | Current data PID code |
| pktCnt | output | 10 | Packets still expected |
| xferSize | output | 19 | Bytes remaining |
| bufAddr | output | 32 | Current buffer address |
| chanActive | output | 1 | Transfer in progress |
| doneIrq | output | 1 | Sticky completion interrupt |

## Verification
Two pairs of functions can fall in the same cycle. In the first, the packet that completes the transfer arrives together with a software write-one-to-clear of the completion flag. The bench drives both in one cycle on a single-packet transfer and expects the flag to read high afterwards. In the second, a successful packet arrives together with a bus beat. The bench expects the count, size and PID to move and the address to advance by 4, all in that one cycle.

// File: rtl/xfer_trk_pkg.sv
package xfer_trk_pkg;

  localparam int DATA_W    = 32;
  localparam int PID_LSB   = 0;
  localparam int CNT_LSB   = 2;
  localparam int START_BIT = 31;
  localparam int CLR_BIT   = 0;

  localparam logic [1:0] SEL_XFER = 2'd0;
  localparam logic [1:0] SEL_ADDR = 2'd1;
  localparam logic [1:0] SEL_STAT = 2'd2;

  typedef enum logic [1:0] {
    PID_DATA0 = 2'b00,
    PID_DATA2 = 2'b01,
    PID_DATA1 = 2'b10,
    PID_SETUP = 2'b11
  } pid_e;

  typedef struct packed {
    logic loadXfer;
    logic loadAddr;
    logic pktAdv;
    logic beatAdv;
  } dpStrobes_t;

endpackage

// File: rtl/xfer_trk_ctrl.sv
module xfer_trk_ctrl
  import xfer_trk_pkg::*;
#(
  parameter int CNT_W   = 10,
  parameter int BYTES_W = 11,
  parameter int MAX_PKT = 64
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               wrEn,
  input  logic [1:0]         wrSel,
  input  logic               startBit,
  input  logic               clrBit,
  input  logic [CNT_W-1:0]   cntField,
  input  logic               chanIsIn,
  input  logic               pktDone,
  input  logic               pktOk,
  input  logic [BYTES_W-1:0] pktBytes,
  input  logic               beat,
  input  logic [CNT_W-1:0]   curCnt,
  output logic               chanActive,
  output logic               doneIrq,
  output dpStrobes_t         strb
);

  localparam logic [CNT_W-1:0]   CNT_ONE   = CNT_W'(1);
  localparam logic [BYTES_W-1:0] SHORT_LIM = BYTES_W'(MAX_PKT);

  logic activeQ, doneQ;
  logic wrXfer, wrAddr, wrClr;
  logic startNow, startEmpty, lastPkt, shortIn, finish, doneSet;

  always_comb begin
    wrXfer     = wrEn && (wrSel == SEL_XFER) && !activeQ;
    wrAddr     = wrEn && (wrSel == SEL_ADDR) && !activeQ;
    wrClr      = wrEn && (wrSel == SEL_STAT) && clrBit;
    startNow   = wrXfer && startBit && (cntField != '0);
    startEmpty = wrXfer && startBit && (cntField == '0);

    strb.loadXfer = wrXfer;
    strb.loadAddr = wrAddr;
    strb.pktAdv   = activeQ && pktDone && pktOk;
    strb.beatAdv  = activeQ && beat;

    lastPkt = (curCnt == CNT_ONE);
    shortIn = chanIsIn && (pktBytes < SHORT_LIM);
    finish  = strb.pktAdv && (lastPkt || shortIn);
    doneSet = finish || startEmpty;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      activeQ <= 1'b0;
      doneQ   <= 1'b0;
    end else begin
      if (startNow)    activeQ <= 1'b1;
      else if (finish) activeQ <= 1'b0;

      if (doneSet)    doneQ <= 1'b1;
      else if (wrClr) doneQ <= 1'b0;
    end
  end

  assign chanActive = activeQ;
  assign doneIrq    = doneQ;

endmodule

// File: rtl/xfer_trk_dp.sv
module xfer_trk_dp
  import xfer_trk_pkg::*;
#(
  parameter int CNT_W      = 10,
  parameter int SIZE_W     = 19,
  parameter int ADDR_W     = 32,
  parameter int BYTES_W    = 11,
  parameter int BEAT_BYTES = 4
) (
  input  logic               clk,
  input  logic               rstN,
  input  dpStrobes_t         strb,
  input  logic [1:0]         pidField,
  input  logic [CNT_W-1:0]   cntField,
  input  logic [SIZE_W-1:0]  sizeField,
  input  logic [ADDR_W-1:0]  addrField,
  input  logic               chanIsCtrl,
  input  logic [BYTES_W-1:0] pktBytes,
  output logic [1:0]         pid,
  output logic [CNT_W-1:0]   pktCnt,
  output logic [SIZE_W-1:0]  xferSize,
  output logic [ADDR_W-1:0]  bufAddr
);

  localparam logic [ADDR_W-1:0] ADDR_STEP = ADDR_W'(BEAT_BYTES);

  pid_e              pidQ, pidNext;
  logic [CNT_W-1:0]  cntQ;
  logic [SIZE_W-1:0] sizeQ, sizeNext, bytesExt;
  logic [ADDR_W-1:0] addrQ;

  always_comb begin
    unique case (pidQ)
      PID_DATA0: pidNext = PID_DATA1;
      PID_DATA1: pidNext = PID_DATA0;
      PID_SETUP: pidNext = chanIsCtrl ? PID_DATA1 : PID_SETUP;
      default:   pidNext = pidQ;
    endcase
  end

  always_comb begin
    bytesExt = SIZE_W'(pktBytes);
    sizeNext = (bytesExt >= sizeQ) ? '0 : (sizeQ - bytesExt);
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      pidQ  <= PID_DATA0;
      cntQ  <= '0;
      sizeQ <= '0;
    end else if (strb.loadXfer) begin
      pidQ  <= pid_e'(pidField);
      cntQ  <= cntField;
      sizeQ <= sizeField;
    end else if (strb.pktAdv) begin
      pidQ  <= pidNext;
      cntQ  <= cntQ - CNT_W'(1);
      sizeQ <= sizeNext;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN)              addrQ <= '0;
    else if (strb.loadAddr) addrQ <= addrField;
    else if (strb.beatAdv)  addrQ <= addrQ + ADDR_STEP;
  end

  assign pid      = pidQ;
  assign pktCnt   = cntQ;
  assign xferSize = sizeQ;
  assign bufAddr  = addrQ;

endmodule

// File: rtl/xfer_trk.sv
module xfer_trk
  import xfer_trk_pkg::*;
#(
  parameter int CNT_W      = 10,
  parameter int SIZE_W     = 19,
  parameter int ADDR_W     = 32,
  parameter int BYTES_W    = 11,
  parameter int MAX_PKT    = 64,
  parameter int BEAT_BYTES = 4
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               wrEn,
  input  logic [1:0]         wrSel,
  input  logic [31:0]        wrData,
  input  logic               chanIsCtrl,
  input  logic               chanIsIn,
  input  logic               pktDone,
  input  logic               pktOk,
  input  logic [BYTES_W-1:0] pktBytes,
  input  logic               beat,
  output logic [1:0]         pid,
  output logic [CNT_W-1:0]   pktCnt,
  output logic [SIZE_W-1:0]  xferSize,
  output logic [ADDR_W-1:0]  bufAddr,
  output logic               chanActive,
  output logic               doneIrq
);

  localparam int SIZE_LSB = CNT_LSB + CNT_W;

  dpStrobes_t strb;
  logic [CNT_W-1:0] cntField;

  assign cntField = wrData[CNT_LSB +: CNT_W];

  xfer_trk_ctrl #(
    .CNT_W  (CNT_W),
    .BYTES_W(BYTES_W),
    .MAX_PKT(MAX_PKT)
  ) u_ctrl (
    .clk       (clk),
    .rstN      (rstN),
    .wrEn      (wrEn),
    .wrSel     (wrSel),
    .startBit  (wrData[START_BIT]),
    .clrBit    (wrData[CLR_BIT]),
    .cntField  (cntField),
    .chanIsIn  (chanIsIn),
    .pktDone   (pktDone),
    .pktOk     (pktOk),
    .pktBytes  (pktBytes),
    .beat      (beat),
    .curCnt    (pktCnt),
    .chanActive(chanActive),
    .doneIrq   (doneIrq),
    .strb      (strb)
  );

  xfer_trk_dp #(
    .CNT_W     (CNT_W),
    .SIZE_W    (SIZE_W),
    .ADDR_W    (ADDR_W),
    .BYTES_W   (BYTES_W),
    .BEAT_BYTES(BEAT_BYTES)
  ) u_dp (
    .clk       (clk),
    .rstN      (rstN),
    .strb      (strb),
    .pidField  (wrData[PID_LSB +: 2]),
    .cntField  (cntField),
    .sizeField (wrData[SIZE_LSB +: SIZE_W]),
    .addrField (wrData[ADDR_W-1:0]),
    .chanIsCtrl(chanIsCtrl),
    .pktBytes  (pktBytes),
    .pid       (pid),
    .pktCnt    (pktCnt),
    .xferSize  (xferSize),
    .bufAddr   (bufAddr)
  );

endmodule

// File: rtl/xfer_trk_chk.sv
module xfer_trk_chk #(
  parameter int CNT_W      = 10,
  parameter int SIZE_W     = 19,
  parameter int ADDR_W     = 32,
  parameter int BEAT_BYTES = 4
) (
  input logic              clk,
  input logic              rstN,
  input logic              wrEn,
  input logic [1:0]        wrSel,
  input logic [31:0]       wrData,
  input logic              pktDone,
  input logic              pktOk,
  input logic              beat,
  input logic [1:0]        pid,
  input logic [CNT_W-1:0]  pktCnt,
  input logic [SIZE_W-1:0] xferSize,
  input logic [ADDR_W-1:0] bufAddr,
  input logic              chanActive,
  input logic              doneIrq
);

  logic goodPkt, clrWrite;
  assign goodPkt  = chanActive && pktDone && pktOk;
  assign clrWrite = wrEn && (wrSel == 2'd2) && wrData[0];

  // R3: each successful packet while active lowers the count by one
  assert_pkt_dec_R3: assert property (@(posedge clk) disable iff (!rstN)
    goodPkt |=> (pktCnt == $past(pktCnt) - CNT_W'(1)));

  // R4: the last packet ends the transfer and raises completion
  assert_last_pkt_R4: assert property (@(posedge clk) disable iff (!rstN)
    (goodPkt && pktCnt == CNT_W'(1)) |=> (doneIrq && !chanActive));

  // R5: a failed packet leaves all tracked state as it was
  assert_fail_hold_R5: assert property (@(posedge clk) disable iff (!rstN)
    (chanActive && pktDone && !pktOk && !beat && !wrEn) |=>
      ($stable(pid) && $stable(pktCnt) && $stable(xferSize) && $stable(bufAddr)));

  // R7: a beat while active advances the address by one beat
  assert_addr_step_R7: assert property (@(posedge clk) disable iff (!rstN)
    (chanActive && beat) |=> (bufAddr == $past(bufAddr) + ADDR_W'(BEAT_BYTES)));

  // R10: completion flag is sticky until cleared
  assert_done_sticky_R10: assert property (@(posedge clk) disable iff (!rstN)
    (doneIrq && !clrWrite) |=> doneIrq);

  // R2: the channel only becomes active through a start write
  assert_start_only_R2: assert property (@(posedge clk) disable iff (!rstN)
    $rose(chanActive) |-> $past(wrEn && wrSel == 2'd0 && wrData[31]));

endmodule

bind xfer_trk xfer_trk_chk #(
  .CNT_W     (CNT_W),
  .SIZE_W    (SIZE_W),
  .ADDR_W    (ADDR_W),
  .BEAT_BYTES(BEAT_BYTES)
) u_chk (
  .clk       (clk),
  .rstN      (rstN),
  .wrEn      (wrEn),
  .wrSel     (wrSel),
  .wrData    (wrData),
  .pktDone   (pktDone),
  .pktOk     (pktOk),
  .beat      (beat),
  .pid       (pid),
  .pktCnt    (pktCnt),
  .xferSize  (xferSize),
  .bufAddr   (bufAddr),
  .chanActive(chanActive),
  .doneIrq   (doneIrq)
);

// File: tb/xfer_trk_bench.sv
`timescale 1ns/1ps
module xfer_trk_bench;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        wrEn = 1'b0;
  logic [1:0]  wrSel = 2'd0;
  logic [31:0] wrData = '0;
  logic        chanIsCtrl = 1'b0, chanIsIn = 1'b0;
  logic        pktDone = 1'b0, pktOk = 1'b0, beat = 1'b0;
  logic [10:0] pktBytes = '0;
  logic [1:0]  pid;
  logic [9:0]  pktCnt;
  logic [18:0] xferSize;
  logic [31:0] bufAddr;
  logic        chanActive, doneIrq;

  int nRun = 0, nFail = 0;

  always #4 clk = ~clk;

  xfer_trk u_xfer_trk (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrSel(wrSel), .wrData(wrData),
    .chanIsCtrl(chanIsCtrl), .chanIsIn(chanIsIn), .pktDone(pktDone),
    .pktOk(pktOk), .pktBytes(pktBytes), .beat(beat), .pid(pid),
    .pktCnt(pktCnt), .xferSize(xferSize), .bufAddr(bufAddr),
    .chanActive(chanActive), .doneIrq(doneIrq)
  );

  // transfer word: start bit 31, size 30:12, count 11:2, pid 1:0
  function automatic logic [31:0] mkXfer(input logic st, input logic [1:0] p,
                                         input int c, input int s);
    return {st, 19'(s), 10'(c), p};
  endfunction

  typedef struct packed {
    logic        wrEn;
    logic [1:0]  wrSel;
    logic [31:0] wrData;
    logic        pktDone;
    logic        pktOk;
    logic [10:0] bytes;
    logic        beat;
    logic        isIn;
    logic        isCtrl;
    logic [1:0]  ePid;
    logic [9:0]  eCnt;
    logic [18:0] eSize;
    logic [31:0] eAddr;
    logic        eAct;
    logic        eDone;
    logic [7:0]  req;
  } vec_t;

  localparam int NV = 19;
  localparam vec_t VECS [NV] = '{
    '{1, 1, 32'h1000, 0, 0, 0, 0, 0, 0,             0, 0, 0, 32'h1000, 0, 0, 2},   // R2 address
    '{1, 0, mkXfer(1, 0, 3, 200), 0, 0, 0, 0, 0, 0, 0, 3, 200, 32'h1000, 1, 0, 2}, // R2 start
    '{0, 0, 0, 0, 0, 0, 1, 0, 0,                    0, 3, 200, 32'h1004, 1, 0, 7}, // R7 beat
    '{0, 0, 0, 1, 1, 64, 1, 0, 0,                   2, 2, 136, 32'h1008, 1, 0, 3}, // R3 pkt+beat
    '{0, 0, 0, 1, 0, 64, 0, 0, 0,                   2, 2, 136, 32'h1008, 1, 0, 5}, // R5 failed
    '{1, 0, mkXfer(1, 0, 7, 999), 0, 0, 0, 0, 0, 0, 2, 2, 136, 32'h1008, 1, 0, 11},// R11
    '{0, 0, 0, 1, 1, 64, 0, 0, 0,                   0, 1, 72, 32'h1008, 1, 0, 6},  // R6 toggle
    '{0, 0, 0, 1, 1, 100, 0, 0, 0,                  2, 0, 0, 32'h1008, 0, 1, 4},   // R4 + R8 sat
    '{0, 0, 0, 0, 0, 0, 1, 0, 0,                    2, 0, 0, 32'h1008, 0, 1, 7},   // R7 idle beat
    '{0, 0, 0, 1, 1, 64, 0, 0, 0,                   2, 0, 0, 32'h1008, 0, 1, 3},   // R3 idle pkt
    '{1, 2, 0, 0, 0, 0, 0, 0, 0,                    2, 0, 0, 32'h1008, 0, 1, 10},  // R10 no bit
    '{1, 2, 1, 0, 0, 0, 0, 0, 0,                    2, 0, 0, 32'h1008, 0, 0, 10},  // R10 clear
    '{1, 0, mkXfer(1, 3, 2, 16), 0, 0, 0, 0, 0, 1,  3, 2, 16, 32'h1008, 1, 0, 2},  // R2 setup
    '{0, 0, 0, 1, 1, 8, 0, 0, 1,                    2, 1, 8, 32'h1008, 1, 0, 6},   // R6 setup->d1
    '{0, 0, 0, 1, 1, 8, 0, 0, 1,                    0, 0, 0, 32'h1008, 0, 1, 4},   // R4
    '{1, 2, 1, 0, 0, 0, 0, 0, 0,                    0, 0, 0, 32'h1008, 0, 0, 10},  // R10
    '{1, 0, mkXfer(1, 1, 2, 0), 0, 0, 0, 0, 0, 0,   1, 2, 0, 32'h1008, 1, 0, 2},   // R2 data2
    '{0, 0, 0, 1, 1, 0, 0, 0, 0,                    1, 1, 0, 32'h1008, 1, 0, 6},   // R6 hold
    '{0, 0, 0, 1, 1, 0, 0, 0, 0,                    1, 0, 0, 32'h1008, 0, 1, 4}    // R4
  };

  task automatic chk(input string req, input string what,
                     input logic [31:0] got, input logic [31:0] exp);
    nRun++;
    if (got !== exp) begin
      nFail++;
      $display("FAIL %s %s: got %0h expected %0h", req, what, got, exp);
    end
  endtask

  task automatic applyStep(input logic we, input logic [1:0] sel, input logic [31:0] d,
                           input logic pd, input logic ok, input logic [10:0] nb,
                           input logic bt, input logic in, input logic ctl);
    @(negedge clk);
    wrEn = we; wrSel = sel; wrData = d; pktDone = pd; pktOk = ok;
    pktBytes = nb; beat = bt; chanIsIn = in; chanIsCtrl = ctl;
    @(posedge clk);
    #1;
    wrEn = 1'b0; pktDone = 1'b0; pktOk = 1'b0; beat = 1'b0; pktBytes = '0;
  endtask

  task automatic chkAll(input string req, input logic [1:0] eP, input logic [9:0] eC,
                        input logic [18:0] eS, input logic [31:0] eA,
                        input logic eAct, input logic eDn);
    chk(req, "pid", 32'(pid), 32'(eP));
    chk(req, "pktCnt", 32'(pktCnt), 32'(eC));
    chk(req, "xferSize", 32'(xferSize), 32'(eS));
    chk(req, "bufAddr", bufAddr, eA);
    chk(req, "chanActive", 32'(chanActive), 32'(eAct));
    chk(req, "doneIrq", 32'(doneIrq), 32'(eDn));
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    nFail++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("  [TB] %0d tests run, %0d failed", nRun, nFail);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #1;
    chkAll("R1", 0, 0, 0, 0, 0, 0);   // R1 reset state
    @(negedge clk);
    rstN = 1'b1;

    for (int i = 0; i < NV; i++) begin
      applyStep(VECS[i].wrEn, VECS[i].wrSel, VECS[i].wrData, VECS[i].pktDone,
                VECS[i].pktOk, VECS[i].bytes, VECS[i].beat, VECS[i].isIn,
                VECS[i].isCtrl);
      chkAll($sformatf("R%0d", VECS[i].req), VECS[i].ePid, VECS[i].eCnt,
             VECS[i].eSize, VECS[i].eAddr, VECS[i].eAct, VECS[i].eDone);
    end

    // R10: completion and clear in the same cycle, set wins
    applyStep(1, 2, 1, 0, 0, 0, 0, 0, 0);
    applyStep(1, 0, mkXfer(1, 0, 1, 64), 0, 0, 0, 0, 0, 0);
    chkAll("R10", 0, 1, 64, 32'h1008, 1, 0);
    applyStep(1, 2, 1, 1, 1, 64, 0, 0, 0);
    chkAll("R10", 2, 0, 0, 32'h1008, 0, 1);

    // R9: short IN packet ends the transfer early
    applyStep(1, 2, 1, 0, 0, 0, 0, 1, 0);
    applyStep(1, 0, mkXfer(1, 0, 5, 512), 0, 0, 0, 0, 1, 0);
    applyStep(0, 0, 0, 1, 1, 64, 0, 1, 0);
    chkAll("R9", 2, 4, 448, 32'h1008, 1, 0);
    applyStep(0, 0, 0, 1, 1, 20, 0, 1, 0);
    chkAll("R9", 0, 3, 428, 32'h1008, 0, 1);

    // R2: start with a zero count completes at once and stays idle
    applyStep(1, 2, 1, 0, 0, 0, 0, 0, 0);
    applyStep(1, 0, mkXfer(1, 2, 0, 50), 0, 0, 0, 0, 0, 0);
    chkAll("R2", 2, 0, 50, 32'h1008, 0, 1);

    // R2: load without start bit; R3: packets while idle ignored
    applyStep(1, 2, 1, 0, 0, 0, 0, 0, 0);
    applyStep(1, 0, mkXfer(0, 0, 4, 40), 0, 0, 0, 0, 0, 0);
    chkAll("R2", 0, 4, 40, 32'h1008, 0, 0);
    applyStep(0, 0, 0, 1, 1, 8, 0, 0, 0);
    chkAll("R3", 0, 4, 40, 32'h1008, 0, 0);

    // R11: address write while active ignored; R7: beat advances
    applyStep(1, 0, mkXfer(1, 0, 2, 10), 0, 0, 0, 0, 0, 0);
    applyStep(1, 1, 32'hDEAD0000, 0, 0, 0, 0, 0, 0);
    chkAll("R11", 0, 2, 10, 32'h1008, 1, 0);
    applyStep(0, 0, 0, 0, 0, 0, 1, 0, 0);
    chkAll("R7", 0, 2, 10, 32'h100C, 1, 0);

    $display("  [TB] %0d tests run, %0d failed", nRun, nFail);
    $finish;
  end

endmodule